// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block keeps a small, fully associative set of recently used virtual-to-physical page mappings. Every stored mapping carries the address space identifier (ASID) of the process that owns it. Mappings from several processes can therefore sit in the cache together, and a context switch does not force a flush. A lookup presents a 32-bit virtual address, the current ASID and the kind of access. In the same cycle the block compares every entry in parallel and reports a hit with the physical address, a miss, or a protection fault. The 12 low address bits are the page offset and pass through untranslated. The upper 20 bits form the virtual page number, which is replaced by the stored physical frame number.

After a miss, an external page-table walker loads the missing mapping through a valid/ready refill port. A refill is taken on a clock edge where `rf_valid` and `rf_ready` are both high. The walker must hold the refill fields stable while `rf_valid` is high and `rf_ready` is low. `rf_ready` drops only while an invalidate command is present, because the invalidate has priority. A refill fills the lowest-numbered empty slot. When no slot is empty, it replaces the slot chosen by a round-robin pointer.

A separate single-cycle command drops every non-global mapping that belongs to one ASID. An entry marked global matches under any ASID and survives that command.

Top module: `asid_tlb`

## Requirements
- R1: A lookup (`lk_valid` high) hits when some valid entry has the same virtual page number (`lk_vaddr[31:12]`) and either the same ASID or its global flag set. `lk_paddr` is then `{frame, lk_vaddr[11:0]}`, produced combinationally in the same cycle.
- R2: A lookup with no matching entry raises `lk_miss` and leaves `lk_hit` low. When `lk_valid` is low, `lk_hit`, `lk_miss` and `lk_fault` are all low.
- R3: The page offset `lk_vaddr[11:0]` appears unchanged in `lk_paddr[11:0]` on every translated hit.
- R4: A global entry matches a lookup under any ASID. A non-global entry matches only under its own ASID.
- R5: A refill is accepted on a rising edge with `rf_valid` and `rf_ready` both high, and a lookup hits on it from the next cycle. `rf_ready` is low exactly while `inv_req` is high.
- R6: A refill writes the lowest-numbered invalid slot whenever one exists, and it does not advance the replacement pointer.
- R7: When every slot is valid, a refill replaces the slot under the round-robin pointer. The pointer starts at slot 0 after reset and moves to the next slot, wrapping at the last one, after each such replacement.
- R8: `inv_req` invalidates, in one cycle, every valid non-global entry whose ASID equals `inv_asid`. Global entries and entries of other ASIDs keep hitting.
- R9: Rights bit 0 allows reads, bit 1 writes and bit 2 execution. `lk_op` encodes 0 read, 1 write, 2 execute; the value 3 is never allowed. A hit whose operation is not allowed raises `lk_fault` together with `lk_hit`. `lk_paddr` is zero on a fault, on a miss and when idle.
- R10: When several entries match one lookup, the lowest-numbered one supplies the frame and the rights.
- R11: After reset every entry is invalid, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup present this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address space identifier |
| lk_op | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| lk_hit | output | 1 | A matching entry was found |
| lk_miss | output | 1 | No entry matched |
| lk_fault | output | 1 | Match found but access kind not permitted |
| lk_paddr | output | 32 | Translated physical address, zero unless a permitted hit |
| rf_valid | input | 1 | Refill entry offered |
| rf_ready | output | 1 | Refill can be accepted this cycle |
| rf_vpn | input | 20 | Refill virtual page number |
| rf_pfn | input | 20 | Refill physical frame number |
| rf_asid | input | 8 | Refill owner ASID |
| rf_global | input | 1 | Refill entry matches any ASID |
| rf_rights | input | 3 | Refill rights {exec, write, read} |
| inv_req | input | 1 | Invalidate all non-global entries of one ASID |
| inv_asid | input | 8 | ASID to invalidate |

## Verification
The bench fills all sixteen slots and then refills twice more. If the victim logic were wrong, the wrong older mapping would disappear: a pointer that does not start at zero or does not advance would evict an unexpected page. Two cases target the interaction between empty slots and the pointer. After an invalidate opens holes, refills must fill those holes without moving the pointer. If they did not, a still-needed page would be evicted early and the following eviction would land on the wrong slot. Two further cases are a duplicate mapping, where the higher-numbered entry must not win, and a global page queried under a foreign ASID, which must hit. Rights checks for write and execute against a read-only page catch a design that ignores the access kind or leaks the address on a fault.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W     = 32;
  localparam int OFF_W    = 12;
  localparam int VPN_W    = VA_W - OFF_W;
  localparam int PFN_W    = 20;
  localparam int ASID_W   = 8;
  localparam int RIGHTS_W = 3;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_EXEC  = 2'd2,
    OP_RSVD  = 2'd3
  } tlb_op_e;

  typedef struct packed {
    logic                valid;
    logic                glb;
    logic [ASID_W-1:0]   asid;
    logic [VPN_W-1:0]    vpn;
    logic [PFN_W-1:0]    pfn;
    logic [RIGHTS_W-1:0] rights;
  } tlb_entry_t;
endpackage

// File: rtl/tlb_first_set.sv
module tlb_first_set #(
  parameter int N     = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
    any = |vec;
  end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  tlb_entry_t         ent [ENTRIES],
  input  logic [VPN_W-1:0]   vpn,
  input  logic [ASID_W-1:0]  asid,
  output logic [ENTRIES-1:0] hit_vec
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = ent[g].valid && (ent[g].vpn == vpn) &&
                        (ent[g].glb || (ent[g].asid == asid));
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               alloc,
  output logic [IDX_W-1:0]   victim
);
  logic             free_any;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] rr_q;

  tlb_first_set #(.N(ENTRIES)) u_free (
    .vec (~valid_vec),
    .any (free_any),
    .idx (free_idx)
  );

  assign victim = free_any ? free_idx : rr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (alloc && !free_any) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lk_valid,
  input  logic [VA_W-1:0]     lk_vaddr,
  input  logic [ASID_W-1:0]   lk_asid,
  input  logic [1:0]          lk_op,
  output logic                lk_hit,
  output logic                lk_miss,
  output logic                lk_fault,
  output logic [VA_W-1:0]     lk_paddr,
  input  logic                rf_valid,
  output logic                rf_ready,
  input  logic [VPN_W-1:0]    rf_vpn,
  input  logic [PFN_W-1:0]    rf_pfn,
  input  logic [ASID_W-1:0]   rf_asid,
  input  logic                rf_global,
  input  logic [RIGHTS_W-1:0] rf_rights,
  input  logic                inv_req,
  input  logic [ASID_W-1:0]   inv_asid
);
  tlb_entry_t         ent_q [ENTRIES];
  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] hit_vec;
  logic               any_hit;
  logic [IDX_W-1:0]   sel_idx;
  logic [IDX_W-1:0]   victim;
  logic               rf_fire;
  tlb_entry_t         sel;
  logic               allowed;
  logic               sel_global;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_vld
    assign valid_vec[g] = ent_q[g].valid;
  end

  assign rf_ready = !inv_req;
  assign rf_fire  = rf_valid && rf_ready;

  tlb_match #(.ENTRIES(ENTRIES)) u_match (
    .ent     (ent_q),
    .vpn     (lk_vaddr[VA_W-1:OFF_W]),
    .asid    (lk_asid),
    .hit_vec (hit_vec)
  );

  tlb_first_set #(.N(ENTRIES)) u_prio (
    .vec (hit_vec),
    .any (any_hit),
    .idx (sel_idx)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_vec (valid_vec),
    .alloc     (rf_fire),
    .victim    (victim)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
    end else if (inv_req) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (!ent_q[i].glb && (ent_q[i].asid == inv_asid)) ent_q[i].valid <= 1'b0;
      end
    end else if (rf_fire) begin
      ent_q[victim] <= '{valid: 1'b1, glb: rf_global, asid: rf_asid,
                         vpn: rf_vpn, pfn: rf_pfn, rights: rf_rights};
    end
  end

  always_comb begin
    sel        = ent_q[sel_idx];
    sel_global = any_hit && sel.glb;
    unique case (tlb_op_e'(lk_op))
      OP_READ:  allowed = sel.rights[0];
      OP_WRITE: allowed = sel.rights[1];
      OP_EXEC:  allowed = sel.rights[2];
      default:  allowed = 1'b0;
    endcase
    lk_hit   = lk_valid && any_hit;
    lk_miss  = lk_valid && !any_hit;
    lk_fault = lk_hit && !allowed;
    lk_paddr = (lk_hit && allowed) ? {sel.pfn, lk_vaddr[OFF_W-1:0]} : '0;
  end
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker
  import tlb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic [VA_W-1:0]   lk_vaddr,
  input logic [ASID_W-1:0] lk_asid,
  input logic              lk_hit,
  input logic              lk_miss,
  input logic              lk_fault,
  input logic [VA_W-1:0]   lk_paddr,
  input logic              rf_ready,
  input logic              inv_req,
  input logic [ASID_W-1:0] inv_asid,
  input logic              sel_global
);
  p_hit_or_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> (lk_hit ^ lk_miss));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_miss && !lk_fault));

  p_offset_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && !lk_fault) |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));

  p_fault_needs_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_hit);

  p_no_leak_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_fault || !lk_hit) |-> (lk_paddr == '0));

  p_inv_stalls_refill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inv_req |-> !rf_ready);

  p_inv_leaves_global_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(inv_req) && lk_hit && (lk_asid == $past(inv_asid))) |-> sel_global);
endmodule

bind asid_tlb tlb_checker u_tlb_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_valid   (lk_valid),
  .lk_vaddr   (lk_vaddr),
  .lk_asid    (lk_asid),
  .lk_hit     (lk_hit),
  .lk_miss    (lk_miss),
  .lk_fault   (lk_fault),
  .lk_paddr   (lk_paddr),
  .rf_ready   (rf_ready),
  .inv_req    (inv_req),
  .inv_asid   (inv_asid),
  .sel_global (sel_global)
);

// File: tb/test_asid_tlb.sv
`timescale 1ns/1ps
module test_asid_tlb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_asid = '0;
  logic [1:0]  lk_op = '0;
  logic        lk_hit, lk_miss, lk_fault;
  logic [31:0] lk_paddr;
  logic        rf_valid = 1'b0;
  logic        rf_ready;
  logic [19:0] rf_vpn = '0;
  logic [19:0] rf_pfn = '0;
  logic [7:0]  rf_asid = '0;
  logic        rf_global = 1'b0;
  logic [2:0]  rf_rights = '0;
  logic        inv_req = 1'b0;
  logic [7:0]  inv_asid = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  asid_tlb i_asid_tlb (
    .clk, .rst_n, .lk_valid, .lk_vaddr, .lk_asid, .lk_op,
    .lk_hit, .lk_miss, .lk_fault, .lk_paddr,
    .rf_valid, .rf_ready, .rf_vpn, .rf_pfn, .rf_asid, .rf_global, .rf_rights,
    .inv_req, .inv_asid
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // expect: 0 miss, 1 hit, 2 fault
  task automatic look(input string req, input logic [31:0] va, input logic [7:0] asid,
                      input logic [1:0] op, input int expect_kind, input logic [19:0] pfn);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; lk_asid = asid; lk_op = op;
    #1;
    chk(req, {29'd0, lk_hit, lk_miss, lk_fault},
        expect_kind == 0 ? 32'b010 : expect_kind == 1 ? 32'b100 : 32'b101);
    chk(req, lk_paddr, expect_kind == 1 ? {pfn, va[11:0]} : 32'd0);
    lk_valid = 1'b0;
  endtask

  task automatic refill(input logic [19:0] vpn, input logic [19:0] pfn,
                        input logic [7:0] asid, input logic glb, input logic [2:0] rights);
    @(negedge clk);
    rf_valid = 1'b1; rf_vpn = vpn; rf_pfn = pfn; rf_asid = asid;
    rf_global = glb; rf_rights = rights;
    @(negedge clk);
    rf_valid = 1'b0;
  endtask

  task automatic t_reset();
    look("R11", 32'h0010_0000, 8'd1, 2'd0, 0, 20'd0);
    look("R11", 32'h0010_F000, 8'd2, 2'd0, 0, 20'd0);
  endtask

  // slots 0..7 asid 1, 8..15 asid 2; slot 3 read-only; slot 15 global
  task automatic t_fill();
    for (int i = 0; i < 16; i++)
      refill(20'h100 + 20'(i), 20'h800 + 20'(i), (i < 8) ? 8'd1 : 8'd2,
             i == 15, (i == 3) ? 3'b001 : 3'b111);
    for (int i = 0; i < 16; i++)
      look("R1", {20'h100 + 20'(i), 12'(i * 37)}, (i < 8) ? 8'd1 : 8'd2, 2'd0, 1,
           20'h800 + 20'(i));
    look("R3", 32'h0010_0FFF, 8'd1, 2'd2, 1, 20'h800);
    look("R2", 32'h0050_0123, 8'd1, 2'd0, 0, 20'd0);
  endtask

  task automatic t_asid();
    look("R4", 32'h0010_F456, 8'd9, 2'd1, 1, 20'h80F);
    look("R4", 32'h0010_1000, 8'd2, 2'd0, 0, 20'd0);
    look("R4", 32'h0010_8000, 8'd1, 2'd0, 0, 20'd0);
  endtask

  task automatic t_rights();
    look("R9", 32'h0010_3abc, 8'd1, 2'd0, 1, 20'h803);
    look("R9", 32'h0010_3abc, 8'd1, 2'd1, 2, 20'd0);
    look("R9", 32'h0010_3abc, 8'd1, 2'd2, 2, 20'd0);
    look("R9", 32'h0010_4abc, 8'd1, 2'd3, 2, 20'd0);
  endtask

  task automatic t_round_robin();
    refill(20'h200, 20'h900, 8'd1, 1'b0, 3'b111);
    look("R7", 32'h0010_0000, 8'd1, 2'd0, 0, 20'd0);
    look("R5", 32'h0020_0010, 8'd1, 2'd0, 1, 20'h900);
    refill(20'h201, 20'h901, 8'd1, 1'b0, 3'b111);
    look("R7", 32'h0010_1000, 8'd1, 2'd0, 0, 20'd0);
    look("R7", 32'h0010_2000, 8'd1, 2'd0, 1, 20'h802);
  endtask

  task automatic t_invalidate();
    @(negedge clk);
    inv_req = 1'b1; inv_asid = 8'd2; rf_valid = 1'b1;
    rf_vpn = 20'h777; rf_pfn = 20'h777; rf_asid = 8'd2; rf_global = 1'b0; rf_rights = 3'b111;
    #1;
    chk("R5", {31'd0, rf_ready}, 32'd0);
    @(negedge clk);
    inv_req = 1'b0; rf_valid = 1'b0;
    look("R5", 32'h0077_7000, 8'd2, 2'd0, 0, 20'd0);
    for (int i = 8; i < 15; i++)
      look("R8", {20'h100 + 20'(i), 12'h0}, 8'd2, 2'd0, 0, 20'd0);
    look("R8", 32'h0010_F000, 8'd2, 2'd0, 1, 20'h80F);
    look("R8", 32'h0010_4000, 8'd1, 2'd0, 1, 20'h804);
  endtask

  task automatic t_holes();
    refill(20'h300, 20'hA00, 8'd3, 1'b0, 3'b111);
    look("R6", 32'h0010_2000, 8'd1, 2'd0, 1, 20'h802);
    look("R6", 32'h0030_0000, 8'd3, 2'd0, 1, 20'hA00);
    for (int i = 1; i < 7; i++) refill(20'h300 + 20'(i), 20'hA00 + 20'(i), 8'd3, 1'b0, 3'b111);
    look("R6", 32'h0010_2000, 8'd1, 2'd0, 1, 20'h802);
    refill(20'h400, 20'hB00, 8'd3, 1'b0, 3'b111);
    look("R6", 32'h0010_2000, 8'd1, 2'd0, 0, 20'd0);
    look("R7", 32'h0010_3000, 8'd1, 2'd0, 1, 20'h803);
    look("R6", 32'h0030_6000, 8'd3, 2'd0, 1, 20'hA06);
  endtask

  task automatic t_priority();
    refill(20'h104, 20'hAAA, 8'd1, 1'b0, 3'b111);
    look("R10", 32'h0010_4321, 8'd1, 2'd0, 1, 20'hAAA);
    look("R7", 32'h0010_3000, 8'd1, 2'd0, 0, 20'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill();
    t_asid();
    t_rights();
    t_round_robin();
    t_invalidate();
    t_holes();
    t_priority();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule